// File: doc/BRIEF.md
# Hall Commutation Decoder with PWM Gating

This block drives a three-phase inverter from three Hall sensors mounted 120 electrical degrees apart. Each Hall level first passes through a two-flop synchroniser and a three-sample agreement filter. The filtered code then selects one high-side switch and one low-side switch on two different phases. Six registered gate commands come out: three high-side and three low-side.

A direction input picks whether the decode drives the rotor forward or in reverse. A quadrant-mode input picks which switches the external PWM-on signal chops:

- In two-quadrant mode, PWM chops the low side only.
- In four-quadrant mode, PWM chops both sides.

Brake turns all high-side switches off and shorts the motor through all three low-side switches. Fault, PWM-off or coast can still remove that low-side short. Coast and undervoltage turn every switch off. The control inputs reach the outputs through the output register only, so they take effect one clock after they are sampled.

Top module: `hall_comm_gate`

## Requirements
- R1: With `rev`=0, `quad4`=1, `pwm_on`=1 and no other control active, the filtered Hall code {A,B,C} drives the phases below. Phase A is bit 0, B is bit 1 and C is bit 2 of `gate_hi` and `gate_lo`.

  | Hall code {A,B,C} | High side | Low side |
  |---|---|---|
  | 101 | A | B |
  | 100 | A | C |
  | 110 | B | C |
  | 010 | B | A |
  | 011 | C | A |
  | 001 | C | B |

- R2: With `rev`=1, each code drives the high side on the phase that is low in R1, and the low side on the phase that is high in R1.
- R3: No phase ever has its high-side and low-side commands on together, and at most one high-side command is on.
- R4: With `quad4`=0 and `pwm_on`=0 in a valid state, the low-side commands are all off and the selected high-side command stays on.
- R5: With `quad4`=1 and `pwm_on`=0, all six commands are off.
- R6: With `brake`=1 and no coast, undervoltage, over-current or PWM-off, `gate_hi`=000 and `gate_lo`=111, whatever the Hall code and direction.
- R7: During brake, `pwm_on`=0 or `ovc`=1 turns all low-side commands off.
- R8: `coast`=1 turns all six commands off, including during brake.
- R9: `uvlo`=1 turns all six commands off.
- R10: The filtered Hall codes 000 and 111 turn all six commands off.
- R11: Outside brake, `ovc`=1 removes commands exactly as `pwm_on`=0 would in the selected quadrant mode.
- R12: A Hall change that lasts 2 cycles or less is ignored. A steady change appears at the outputs on the sixth rising edge after it is applied. A control input change appears on the next rising edge.
- R13: During reset, and until a valid filtered code exists, all six commands are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall | input | 3 | Hall levels: bit 2 is A, bit 1 is B, bit 0 is C |
| rev | input | 1 | Direction select: 1 selects reverse |
| brake | input | 1 | Brake request |
| coast | input | 1 | Coast request: all switches off |
| quad4 | input | 1 | 1 chops both sides, 0 chops the low side only |
| pwm_on | input | 1 | PWM on-interval from the external comparator |
| ovc | input | 1 | Over-current flag |
| uvlo | input | 1 | Undervoltage flag |
| gate_hi | output | 3 | High-side commands: bit 0 is A, bit 1 is B, bit 2 is C |
| gate_lo | output | 3 | Low-side commands: bit 0 is A, bit 1 is B, bit 2 is C |

## Verification
The bench walks all six codes in both directions, so a swapped table row or a reverse decode that is not the exact mirror shows up as a wrong phase. It checks PWM-off in each quadrant mode: a design that chops the high side in two-quadrant mode, or leaves it on in four-quadrant mode, would draw either the wrong current path or an uncontrolled circulating current. Brake is checked against coast, fault and PWM-off vetoes: a design that let brake override them would short the low side during a fault. The bench also applies two-cycle Hall glitches and measures latency cycle by cycle. A design with a short filter would commutate on noise, and an extra register would shift the sampled edge.

// File: rtl/hall_comm_gate.sv
module hall_comm_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall,
  input  logic       rev,
  input  logic       brake,
  input  logic       coast,
  input  logic       quad4,
  input  logic       pwm_on,
  input  logic       ovc,
  input  logic       uvlo,
  output logic [2:0] gate_hi,
  output logic [2:0] gate_lo
);
  localparam logic [2:0] PH_A = 3'b001;
  localparam logic [2:0] PH_B = 3'b010;
  localparam logic [2:0] PH_C = 3'b100;

  logic [2:0] h_s1, h_s2, h_d1, h_d2, h_flt;
  logic [2:0] fwd_hi, fwd_lo, sel_hi, sel_lo;
  logic [2:0] nxt_hi, nxt_lo;
  logic       chop_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_s1  <= 3'b000;
      h_s2  <= 3'b000;
      h_d1  <= 3'b000;
      h_d2  <= 3'b000;
      h_flt <= 3'b000;
    end else begin
      h_s1 <= hall;
      h_s2 <= h_s1;
      h_d1 <= h_s2;
      h_d2 <= h_d1;
      if (h_s2 == h_d1 && h_d1 == h_d2)
        h_flt <= h_s2;
    end
  end

  always_comb begin
    case (h_flt)
      3'b101:  begin fwd_hi = PH_A; fwd_lo = PH_B; end
      3'b100:  begin fwd_hi = PH_A; fwd_lo = PH_C; end
      3'b110:  begin fwd_hi = PH_B; fwd_lo = PH_C; end
      3'b010:  begin fwd_hi = PH_B; fwd_lo = PH_A; end
      3'b011:  begin fwd_hi = PH_C; fwd_lo = PH_A; end
      3'b001:  begin fwd_hi = PH_C; fwd_lo = PH_B; end
      default: begin fwd_hi = 3'b000; fwd_lo = 3'b000; end
    endcase
  end

  assign sel_hi  = rev ? fwd_lo : fwd_hi;
  assign sel_lo  = rev ? fwd_hi : fwd_lo;
  assign chop_on = pwm_on && !ovc;

  always_comb begin
    nxt_hi = 3'b000;
    nxt_lo = 3'b000;
    if (uvlo || coast) begin
      nxt_hi = 3'b000;
      nxt_lo = 3'b000;
    end else if (brake) begin
      nxt_lo = chop_on ? 3'b111 : 3'b000;
    end else begin
      nxt_hi = (quad4 && !chop_on) ? 3'b000 : sel_hi;
      nxt_lo = chop_on ? sel_lo : 3'b000;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hi <= 3'b000;
      gate_lo <= 3'b000;
    end else begin
      gate_hi <= nxt_hi;
      gate_lo <= nxt_lo;
    end
  end
endmodule

// File: rtl/hall_comm_gate_chk.sv
module hall_comm_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       brake,
  input logic       coast,
  input logic       quad4,
  input logic       pwm_on,
  input logic       ovc,
  input logic       uvlo,
  input logic [2:0] gate_hi,
  input logic [2:0] gate_lo
);
  assert_phase_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == 3'b000);
  assert_one_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_hi));
  assert_uvlo_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (gate_hi == 3'b000 && gate_lo == 3'b000));
  assert_coast_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    coast |=> (gate_hi == 3'b000 && gate_lo == 3'b000));
  assert_brake_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brake |=> gate_hi == 3'b000);
  assert_brake_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (brake && !coast && !uvlo && pwm_on && !ovc) |=> gate_lo == 3'b111);
  assert_pwm_lo_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_on |=> gate_lo == 3'b000);
  assert_quad4_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (quad4 && !pwm_on) |=> (gate_hi == 3'b000 && gate_lo == 3'b000));
  assert_ovc_lo_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ovc |=> gate_lo == 3'b000);
endmodule

bind hall_comm_gate hall_comm_gate_chk i_chk (
  .clk(clk), .rst_n(rst_n), .brake(brake), .coast(coast), .quad4(quad4),
  .pwm_on(pwm_on), .ovc(ovc), .uvlo(uvlo), .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/test_hall_comm_gate.sv
module test_hall_comm_gate;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall = 3'b000;
  logic       rev = 1'b0, brake = 1'b0, coast = 1'b0, quad4 = 1'b1;
  logic       pwm_on = 1'b1, ovc = 1'b0, uvlo = 1'b0;
  logic [2:0] gate_hi, gate_lo;
  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hall_comm_gate i_hall_comm_gate (
    .clk(clk), .rst_n(rst_n), .hall(hall), .rev(rev), .brake(brake),
    .coast(coast), .quad4(quad4), .pwm_on(pwm_on), .ovc(ovc), .uvlo(uvlo),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  function automatic logic [5:0] fwd_map(input logic [2:0] code);
    case (code)
      3'b101:  return {3'b001, 3'b010};
      3'b100:  return {3'b001, 3'b100};
      3'b110:  return {3'b010, 3'b100};
      3'b010:  return {3'b010, 3'b001};
      3'b011:  return {3'b100, 3'b001};
      3'b001:  return {3'b100, 3'b010};
      default: return 6'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [2:0] eh, input logic [2:0] el);
    n_chk++;
    if (gate_hi !== eh || gate_lo !== el) begin
      n_err++;
      $display("FAIL %s: got hi=%b lo=%b expected hi=%b lo=%b", req, gate_hi, gate_lo, eh, el);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_hall(input logic [2:0] code);
    hall = code;
    cyc(8);
  endtask

  task automatic t_reset;
    check("R13", 3'b000, 3'b000);
    rst_n = 1'b1;
    cyc(2);
    check("R13", 3'b000, 3'b000);
  endtask

  task automatic t_forward;
    logic [2:0] seq [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
    rev = 1'b0; quad4 = 1'b1; pwm_on = 1'b1;
    for (int i = 0; i < 6; i++) begin
      set_hall(seq[i]);
      check("R1", fwd_map(seq[i])[5:3], fwd_map(seq[i])[2:0]);
    end
  endtask

  task automatic t_reverse;
    logic [2:0] seq [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};
    rev = 1'b1;
    for (int i = 0; i < 6; i++) begin
      set_hall(seq[i]);
      check("R2", fwd_map(seq[i])[2:0], fwd_map(seq[i])[5:3]);
    end
    rev = 1'b0;
    cyc(1);
  endtask

  task automatic t_quadrants;
    set_hall(3'b110);
    quad4 = 1'b0; pwm_on = 1'b0; cyc(1);
    check("R4", 3'b010, 3'b000);
    pwm_on = 1'b1; cyc(1);
    check("R4", 3'b010, 3'b100);
    quad4 = 1'b1; pwm_on = 1'b0; cyc(1);
    check("R5", 3'b000, 3'b000);
    pwm_on = 1'b1; ovc = 1'b1; cyc(1);
    check("R11", 3'b000, 3'b000);
    quad4 = 1'b0; cyc(1);
    check("R11", 3'b010, 3'b000);
    ovc = 1'b0; quad4 = 1'b1; cyc(1);
    check("R11", 3'b010, 3'b100);
  endtask

  task automatic t_brake_coast;
    brake = 1'b1; rev = 1'b1; cyc(1);
    check("R6", 3'b000, 3'b111);
    set_hall(3'b011);
    check("R6", 3'b000, 3'b111);
    pwm_on = 1'b0; cyc(1);
    check("R7", 3'b000, 3'b000);
    pwm_on = 1'b1; ovc = 1'b1; cyc(1);
    check("R7", 3'b000, 3'b000);
    ovc = 1'b0; coast = 1'b1; cyc(1);
    check("R8", 3'b000, 3'b000);
    brake = 1'b0; cyc(1);
    check("R8", 3'b000, 3'b000);
    coast = 1'b0; uvlo = 1'b1; cyc(1);
    check("R9", 3'b000, 3'b000);
    brake = 1'b1; cyc(1);
    check("R9", 3'b000, 3'b000);
    brake = 1'b0; uvlo = 1'b0; rev = 1'b0; cyc(1);
    check("R9", 3'b100, 3'b001);
  endtask

  task automatic t_invalid;
    set_hall(3'b111);
    check("R10", 3'b000, 3'b000);
    set_hall(3'b000);
    check("R10", 3'b000, 3'b000);
  endtask

  task automatic t_filter;
    set_hall(3'b101);
    check("R12", 3'b001, 3'b010);
    hall = 3'b100; cyc(2); hall = 3'b101;
    for (int i = 0; i < 8; i++) begin
      cyc(1);
      check("R12", 3'b001, 3'b010);
    end
    hall = 3'b100; cyc(1); hall = 3'b101;
    cyc(8);
    check("R12", 3'b001, 3'b010);
    hall = 3'b100;
    cyc(5);
    check("R12", 3'b001, 3'b010);
    cyc(1);
    check("R12", 3'b001, 3'b100);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    cyc(3);
    t_reset;
    t_forward;
    t_reverse;
    t_quadrants;
    t_brake_coast;
    t_invalid;
    t_filter;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule